// File: doc/BRIEF.md
# Line Burst Write Master with Asynchronous Acknowledge

This block is a bus master that writes one cache line of four longwords to a 32-bit data bus. A request supplies a longword-aligned base address, four data words and a privilege attribute. The master opens the transfer with a one-clock start strobe that carries the address. It then moves through the line one beat at a time. Each beat drives a data word for one clock and then holds it until the slave acknowledges.

The slave's acknowledge is asynchronous. It passes through a chain of flops clocked on the falling edge before the state machine uses it on the next rising edge. While that synchronized acknowledge stays low, the master inserts wait states and the bus does not change. The longword index field of the address starts at the request's value and advances by one, wrapping within the line, after each acknowledged beat. After the fourth beat a one-clock done pulse marks the return to idle. An optional wait-state watchdog can give up on a silent slave. It then raises a one-clock timeout pulse and also returns to idle.

Top module: `line_burst_writer`

## Requirements
- R1: The clock after a request is accepted is the address phase. In it `bus_start` is 1, `bus_data_oe` is 0, `busy` is 1, and `bus_addr` equals `{req_lw_addr, 2'b00}`. `bus_start` is never high for two clocks in a row.
- R2: The clock after the address phase drives the first beat. `bus_start` is 0 and `bus_data_oe` is 1. `bus_data` carries `req_data[31:0]`. `bus_super` equals `req_super`, where 0 means a user access and 1 a supervisor access.
- R3: `ack_raw` is synchronized by two flops clocked on the falling edge. If it is high before the falling edge inside a beat's drive clock, that beat ends after one hold clock, with no wait state.
- R4: While the synchronized acknowledge is low at the end of a hold clock, the master adds another hold clock. `bus_addr`, `bus_data` and `bus_super` stay unchanged.
- R5: The clock after an acknowledged hold clock drives the next beat. Beat b carries `req_data[32*b+31:32*b]`. The index field `bus_addr[3:2]` increases by one modulo 4. `bus_addr[31:4]` is unchanged for the whole burst.
- R6: A burst consists of exactly four beats. Each beat is one drive clock followed by at least one hold clock.
- R7: The clock after the fourth acknowledged hold clock has `done` = 1 for that clock only. In it the bus is idle: `busy`, `bus_start` and `bus_data_oe` are 0, `bus_addr` and `bus_data` are 0, and `bus_super` is 1.
- R8: A request is accepted only while `busy` is 0. A `req_valid` that arrives during a burst is dropped and does not start a later burst.
- R9: With `wdog_limit` = L > 0, if the acknowledge has not arrived by the end of the L-th hold clock of a beat, the master returns to idle. The next clock then has `timeout` = 1 for one clock and `done` = 0. A beat acknowledged in its L-th hold clock completes normally. The count restarts for every beat.
- R10: With `wdog_limit` = 0, the watchdog is disabled and the master waits for any number of wait states.
- R11: During and after reset, the master is idle: `busy`, `bus_start`, `bus_data_oe`, `done` and `timeout` are 0, `bus_addr` and `bus_data` are 0, and `bus_super` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state on rising edge, synchronizer on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request to start a line write (taken only when idle) |
| req_lw_addr | input | 30 | Longword address of the first beat |
| req_data | input | 128 | Four data words, beat b in bits [32b+31:32b] |
| req_super | input | 1 | Attribute: 0 user, 1 supervisor |
| wdog_limit | input | 8 | Hold clocks allowed per beat; 0 disables the watchdog |
| ack_raw | input | 1 | Asynchronous transfer acknowledge from the slave |
| busy | output | 1 | Burst in progress |
| bus_start | output | 1 | Transfer start strobe (address phase) |
| bus_addr | output | 32 | Byte address on the bus |
| bus_data | output | 32 | Write data |
| bus_data_oe | output | 1 | Data output enable |
| bus_super | output | 1 | Attribute driven in data phase; 1 when not driving |
| done | output | 1 | One-clock pulse after the last beat |
| timeout | output | 1 | One-clock pulse after a watchdog abort |

## Verification
The address phase appears one clock after the accepting edge, and the first drive clock one clock after that. An acknowledge raised just after the rising edge that opens a clock is seen by the state machine two rising edges later. So when the bench raises it in hold clock j (or in the drive clock, taken as j = 0), the next beat shows on the bus in the clock after hold clock j+1. The done or timeout pulse shows in the clock after the deciding hold clock. The bench raises each acknowledge at a computed offset inside the beat and then checks every clock of the burst, one time unit after the rising edge. It checks the control bits, the address and the data against values it derives from the request and the wait pattern.

// File: rtl/lbw_pkg.sv
package lbw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ADDR  = 2'd1,
      ST_DRIVE = 2'd2,
      ST_HOLD  = 2'd3
   } lbw_state_e;
endpackage

// File: rtl/lbw_ack_sync.sv
module lbw_ack_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_raw,
   output logic ack_sync
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("lbw_ack_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   // Falling-edge chain: the result is settled before the next rising edge.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], ack_raw};
   end

   assign ack_sync = chain[STAGES-1];
endmodule

// File: rtl/lbw_wait_wdog.sv
module lbw_wait_wdog #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             expire
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end

   // cnt holds the ackless hold clocks before this one.
   assign expire = (limit != '0) && tick && (cnt == limit - 1'b1);
endmodule

// File: rtl/lbw_beat_fsm.sv
module lbw_beat_fsm
   import lbw_pkg::*;
#(
   parameter int BEATS = 4,
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [IDX_W-1:0] go_idx,
   input  logic             ack,
   input  logic             expire,
   output lbw_state_e       state,
   output logic [IDX_W-1:0] beat,
   output logic [IDX_W-1:0] idx,
   output logic             done,
   output logic             timeout
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(BEATS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         beat    <= '0;
         idx     <= '0;
         done    <= 1'b0;
         timeout <= 1'b0;
      end else begin
         done    <= 1'b0;
         timeout <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (go) begin
                  state <= ST_ADDR;
                  beat  <= '0;
                  idx   <= go_idx;
               end
            end
            ST_ADDR:  state <= ST_DRIVE;
            ST_DRIVE: state <= ST_HOLD;
            ST_HOLD: begin
               if (ack) begin
                  if (beat == LAST) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                  end else begin
                     state <= ST_DRIVE;
                     beat  <= beat + 1'b1;
                     idx   <= idx + 1'b1;
                  end
               end else if (expire) begin
                  state   <= ST_IDLE;
                  timeout <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/line_burst_writer.sv
module line_burst_writer
   import lbw_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int BEATS       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int WDOG_W      = 8,
   localparam int OFS        = $clog2(DATA_W / 8),
   localparam int IDX_W      = $clog2(BEATS),
   localparam int LW_W       = ADDR_W - OFS,
   localparam int HI_W       = LW_W - IDX_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [LW_W-1:0]         req_lw_addr,
   input  logic [BEATS*DATA_W-1:0] req_data,
   input  logic                    req_super,
   input  logic [WDOG_W-1:0]       wdog_limit,
   input  logic                    ack_raw,
   output logic                    busy,
   output logic                    bus_start,
   output logic [ADDR_W-1:0]       bus_addr,
   output logic [DATA_W-1:0]       bus_data,
   output logic                    bus_data_oe,
   output logic                    bus_super,
   output logic                    done,
   output logic                    timeout
);
   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_dw
         $error("line_burst_writer: DATA_W must be a power of two >= 8");
      end
      if (BEATS < 2 || (BEATS & (BEATS - 1)) != 0) begin : g_bad_beats
         $error("line_burst_writer: BEATS must be a power of two >= 2");
      end
      if (HI_W < 1) begin : g_bad_aw
         $error("line_burst_writer: ADDR_W too small for the line");
      end
      if (WDOG_W < 1) begin : g_bad_wd
         $error("line_burst_writer: WDOG_W must be positive");
      end
   endgenerate

   lbw_state_e        state;
   logic [IDX_W-1:0]  beat, idx;
   logic              ack_sync, expire, go, in_hold;
   logic [HI_W-1:0]   base_hi;
   logic              super_q;
   logic [DATA_W-1:0] words [BEATS];

   assign go      = req_valid && (state == ST_IDLE);
   assign in_hold = (state == ST_HOLD);

   lbw_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .ack_raw  (ack_raw),
      .ack_sync (ack_sync)
   );

   lbw_wait_wdog #(.CNT_W(WDOG_W)) u_wdog (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (!in_hold || ack_sync),
      .tick   (in_hold && !ack_sync),
      .limit  (wdog_limit),
      .expire (expire)
   );

   lbw_beat_fsm #(.BEATS(BEATS), .IDX_W(IDX_W)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .go_idx  (req_lw_addr[IDX_W-1:0]),
      .ack     (ack_sync),
      .expire  (expire),
      .state   (state),
      .beat    (beat),
      .idx     (idx),
      .done    (done),
      .timeout (timeout)
   );

   // Request capture: the request is held for the whole burst.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_hi <= '0;
         super_q <= 1'b1;
      end else if (go) begin
         base_hi <= req_lw_addr[LW_W-1:IDX_W];
         super_q <= req_super;
      end
   end

   for (genvar g = 0; g < BEATS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  words[g] <= '0;
         else if (go) words[g] <= req_data[g*DATA_W +: DATA_W];
      end
   end

   assign busy        = (state != ST_IDLE);
   assign bus_start   = (state == ST_ADDR);
   assign bus_data_oe = (state == ST_DRIVE) || in_hold;
   assign bus_addr    = busy ? {base_hi, idx, {OFS{1'b0}}} : '0;
   assign bus_data    = bus_data_oe ? words[beat] : '0;
   assign bus_super   = bus_data_oe ? super_q : 1'b1;
endmodule

// File: rtl/lbw_checker.sv
module lbw_checker #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 2,
   parameter int OFS    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              bus_start,
   input logic              bus_data_oe,
   input logic              done,
   input logic              timeout,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_data
);
   logic [IDX_W-1:0] cur_idx;
   assign cur_idx = bus_addr[OFS +: IDX_W];

   p_start_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> !bus_start);

   p_drive_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> (bus_data_oe && busy));

   p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_data_oe && $past(bus_data_oe) && (bus_addr == $past(bus_addr)))
         |-> (bus_data == $past(bus_data)));

   p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && (cur_idx != $past(cur_idx)))
         |-> (cur_idx == IDX_W'($past(cur_idx) + 1'b1)));

   p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy))
         |-> (bus_addr[ADDR_W-1:OFS+IDX_W] == $past(bus_addr[ADDR_W-1:OFS+IDX_W])));

   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !bus_data_oe && !bus_start));

   p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid) |=> !bus_start);

   p_one_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bus_start, done, timeout}));

   p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> (!busy && !bus_data_oe));
endmodule

bind line_burst_writer lbw_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .IDX_W  (IDX_W),
   .OFS    (OFS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .busy        (busy),
   .bus_start   (bus_start),
   .bus_data_oe (bus_data_oe),
   .done        (done),
   .timeout     (timeout),
   .bus_addr    (bus_addr),
   .bus_data    (bus_data)
);

// File: tb/sim_line_burst_writer.sv
module sim_line_burst_writer;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [29:0]  req_lw_addr = '0;
   logic [127:0] req_data = '0;
   logic         req_super = 1'b0;
   logic [7:0]   wdog_limit = '0;
   logic         ack_raw = 1'b0;
   logic         busy, bus_start, bus_data_oe, bus_super, done, timeout;
   logic [31:0]  bus_addr, bus_data;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   line_burst_writer u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lw_addr(req_lw_addr),
      .req_data(req_data), .req_super(req_super), .wdog_limit(wdog_limit),
      .ack_raw(ack_raw), .busy(busy), .bus_start(bus_start), .bus_addr(bus_addr),
      .bus_data(bus_data), .bus_data_oe(bus_data_oe), .bus_super(bus_super),
      .done(done), .timeout(timeout)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ctrl order: start, oe, busy, done, timeout, super
   task automatic check_bus(input string tag, input logic [5:0] ctrl,
                            input logic [31:0] addr, input logic [31:0] data);
      check({tag, " ctrl"}, {58'd0, bus_start, bus_data_oe, busy, done, timeout, bus_super},
            {58'd0, ctrl});
      check({tag, " addr"}, {32'd0, bus_addr}, {32'd0, addr});
      check({tag, " data"}, {32'd0, bus_data}, {32'd0, data});
   endtask

   function automatic logic [31:0] word_of(input int k, input int b);
      return 32'hC0DE_0000 + 32'(k) * 32'h0000_0101 + 32'(b) * 32'h0011_0000;
   endfunction

   // waits: ackless hold clocks per beat; abort_beat < 0 means none.
   task automatic run_burst(input string grp, input logic [29:0] base, input bit sup,
                            input int wt[4], input int abort_beat, input int lim,
                            input bit poke, input int k);
      logic [1:0] idx;
      int nbeats = 0;
      for (int b = 0; b < 4; b++) req_data[b*32 +: 32] = word_of(k, b);
      req_lw_addr = base;
      req_super   = sup;
      req_valid   = 1'b1;
      ack_raw     = 1'b0;
      step();
      req_valid = 1'b0;
      check_bus({grp, " R1 address phase"}, 6'b101001,
                {base[29:2], base[1:0], 2'b00}, 32'd0);
      for (int b = 0; b < 4; b++) begin
         int n;
         idx = base[1:0] + 2'(b);
         step();
         ack_raw = (b != abort_beat) && (wt[b] == 0);
         if (poke && b == 1) begin
            req_valid   = 1'b1;
            req_lw_addr = 30'h1555_5555;
         end
         nbeats++;
         check_bus({grp, (b == 0) ? " R2 first drive" : " R5 next drive"},
                   {3'b011, 2'b00, sup}, {base[29:2], idx, 2'b00}, word_of(k, b));
         n = (b == abort_beat) ? lim : wt[b] + 1;
         for (int j = 1; j <= n; j++) begin
            step();
            req_valid = 1'b0;
            if (b != abort_beat && j == wt[b]) ack_raw = 1'b1;
            check_bus({grp, (wt[b] == 0) ? " R3 hold" : " R4 wait hold"},
                      {3'b011, 2'b00, sup}, {base[29:2], idx, 2'b00}, word_of(k, b));
         end
         if (b == abort_beat) begin
            step();
            check_bus({grp, " R9 abort"}, 6'b000011, 32'd0, 32'd0);
            step();
            check_bus({grp, " R9 after abort"}, 6'b000001, 32'd0, 32'd0);
            return;
         end
      end
      step();
      ack_raw = 1'b0;
      check_bus({grp, " R7 done pulse"}, 6'b000101, 32'd0, 32'd0);
      check({grp, " R6 beat count"}, 64'(nbeats), 64'd4);
      step();
      check_bus({grp, " R7/R8 idle after done"}, 6'b000001, 32'd0, 32'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int wt[4];
      #3;
      check_bus("R11 in reset", 6'b000001, 32'd0, 32'd0);
      repeat (3) step();
      rst_n = 1'b1;
      step();
      check_bus("R11 after reset", 6'b000001, 32'd0, 32'd0);

      // Sweep: every start index, both attributes, varied wait patterns.
      wdog_limit = 8'd0;
      for (int k = 0; k < 8; k++) begin
         logic [29:0] base;
         base = (30'h0123_4560 ^ (30'(k) << 8)) | 30'(k % 4);
         for (int b = 0; b < 4; b++) wt[b] = (k + b) % 3;
         run_burst("sweep", base, k[2], wt, -1, 0, 1'b0, k);
      end

      // Request during a burst is dropped.
      wt = '{0, 1, 0, 0};
      run_burst("R8 drop", 30'h2AAA_AAA9, 1'b0, wt, -1, 0, 1'b1, 9);

      // Watchdog boundary: L-1 waits pass, L waits abort.
      wdog_limit = 8'd3;
      wt = '{0, 2, 0, 2};
      run_burst("R9 under limit", 30'h0000_0F02, 1'b1, wt, -1, 3, 1'b0, 10);
      wt = '{1, 0, 0, 0};
      run_burst("R9 abort beat2", 30'h0000_0F03, 1'b0, wt, 2, 3, 1'b0, 11);
      wdog_limit = 8'd1;
      run_burst("R9 abort beat0", 30'h0000_0F00, 1'b0, wt, 0, 1, 1'b0, 12);
      wt = '{0, 0, 0, 0};
      run_burst("R9 recovery", 30'h0000_0F01, 1'b1, wt, -1, 1, 1'b0, 13);

      // Disabled watchdog: long waits complete.
      wdog_limit = 8'd0;
      wt = '{20, 0, 7, 300};
      run_burst("R10 no limit", 30'h3FFF_FFFF, 1'b0, wt, -1, 0, 1'b0, 14);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule